// File: doc/BRIEF.md
# Programmable Memory Cycle Stretcher

This block sits beside a Z80-style processor bus and lengthens memory cycles by pulling an active-low wait line. A mode field, written by the processor through an output instruction to one fixed I/O port, sets the policy at run time. Three policies exist: every memory cycle is stretched, only opcode-fetch (M1) cycles are stretched, or nothing is stretched. A turbo input selects a longer stretch for a faster processor clock.

The block samples the memory-request, I/O-request, M1 and write strobes on the rising clock edge. When a memory cycle begins and the current policy covers it, the wait line goes low for a set number of clocks and is then released. A mode write is held back until the I/O cycle that carries it has ended, so it never changes the policy of a cycle already running. The interface is control signalling only: no data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `mem_wait_stretch`

## Requirements
- R1: After reset, wait_n is high and the policy is "no waits": memory cycles are not stretched until a mode write takes place.
- R2: With mode field (data bits 3:2) = 2'b00, every memory cycle is stretched, whether a read, a write or an opcode fetch. wait_n goes low at the first rising edge at which mreq_n is sampled low after being sampled high.
- R3: With mode field = 2'b01, a memory cycle with m1_n sampled low at its first edge is stretched.
- R4: With mode field = 2'b01, memory reads and writes with m1_n high are not stretched. Two back-to-back M1 fetches, a prefix byte followed by an opcode, are each stretched.
- R5: A stretch keeps wait_n low for NORM_WAITS (default 1) cycles when turbo is low at the start edge, and for TURBO_WAITS (default 2) cycles when it is high. wait_n then returns high.
- R6: With mode field = 2'b10 or 2'b11, no memory cycle is stretched.
- R7: I/O cycles (iorq_n low, mreq_n high) never pull wait_n low. An I/O write to any address other than PORT_ADDR (default 8'hBF) leaves the policy unchanged.
- R8: A write to PORT_ADDR (iorq_n, wr_n low, m1_n high) loads only data bits 3:2 and takes effect at the first edge at which iorq_n is sampled high again. Bits 7:4 and 1:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode-fetch marker, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_i | input | 8 | Low address byte (I/O port number) |
| data_i | input | 8 | Processor data bus |
| turbo_i | input | 1 | High selects the longer stretch |
| wait_n | output | 1 | Wait request to the processor, active low |

## Verification
wait_n is registered, so a stretch appears one edge after the falling memory request is first sampled. The bench changes inputs on falling edges and reads wait_n on the next falling edge, then on the following ones, to see the exact number of low cycles. A mode write commits at the edge after iorq_n rises. The first memory cycle after an OUT therefore starts under the new policy, and the bench's expected stretch length uses the value just written. The bench sweeps all 256 data values through the port, with both turbo settings and three cycle kinds for each.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef enum logic [1:0] {
    WM_ALL   = 2'b00,
    WM_FETCH = 2'b01,
    WM_OFF   = 2'b10
  } wmode_e;

  function automatic wmode_e decode_mode(input logic [1:0] fld);
    if (fld[1])      return WM_OFF;
    else if (fld[0]) return WM_FETCH;
    else             return WM_ALL;
  endfunction
endpackage

// File: rtl/wst_port_reg.sv
module wst_port_reg
  import wst_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hBF,
  parameter int FIELD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output wmode_e            mode_o
);
  localparam int FIELD_MSB = FIELD_LSB + 1;

  logic       hit;
  logic       pend_q;
  logic [1:0] pend_fld_q;
  wmode_e     mode_q;
  logic       unused_bits;

  assign hit = !iorq_n && !wr_n && m1_n && (addr_i == PORT_ADDR);
  assign unused_bits = ^data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_fld_q <= 2'b00;
      mode_q     <= WM_OFF;
    end else begin
      if (hit) begin
        pend_q     <= 1'b1;
        pend_fld_q <= data_i[FIELD_MSB:FIELD_LSB];
      end else if (pend_q && iorq_n) begin
        pend_q <= 1'b0;
        mode_q <= decode_mode(pend_fld_q);
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/wst_cycle_detect.sv
module wst_cycle_detect
  import wst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mreq_n,
  input  logic   m1_n,
  input  wmode_e mode_i,
  output logic   start_o
);
  logic mreq_q;
  logic begin_cyc;
  logic covered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreq_q <= 1'b1;
    else        mreq_q <= mreq_n;
  end

  assign begin_cyc = mreq_q && !mreq_n;

  always_comb begin
    unique case (mode_i)
      WM_ALL:   covered = 1'b1;
      WM_FETCH: covered = !m1_n;
      default:  covered = 1'b0;
    endcase
  end

  assign start_o = begin_cyc && covered;
endmodule

// File: rtl/wst_wait_timer.sv
module wst_wait_timer #(
  parameter int NORM_WAITS  = 1,
  parameter int TURBO_WAITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic turbo_i,
  output logic wait_n
);
  localparam int MAXW  = (NORM_WAITS > TURBO_WAITS) ? NORM_WAITS : TURBO_WAITS;
  localparam int CNT_W = (MAXW < 2) ? 1 : $clog2(MAXW + 1);

  generate
    if (MAXW == 1) begin : g_flop
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= start_i;
      end
      assign wait_n = !hold_q;
    end else begin : g_count
      localparam logic [CNT_W-1:0] LOAD_N = CNT_W'(NORM_WAITS);
      localparam logic [CNT_W-1:0] LOAD_T = CNT_W'(TURBO_WAITS);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (start_i)          cnt_q <= turbo_i ? LOAD_T : LOAD_N;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
      end
      assign wait_n = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/mem_wait_stretch.sv
module mem_wait_stretch
  import wst_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hBF,
  parameter int FIELD_LSB   = 2,
  parameter int NORM_WAITS  = 1,
  parameter int TURBO_WAITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              turbo_i,
  output logic              wait_n
);
  wmode_e cur_mode;
  logic   start;

  wst_port_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .FIELD_LSB(FIELD_LSB)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .wr_n(wr_n), .m1_n(m1_n),
    .addr_i(addr_i), .data_i(data_i), .mode_o(cur_mode)
  );

  wst_cycle_detect u_det (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .m1_n(m1_n),
    .mode_i(cur_mode), .start_o(start)
  );

  wst_wait_timer #(
    .NORM_WAITS(NORM_WAITS), .TURBO_WAITS(TURBO_WAITS)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .turbo_i(turbo_i), .wait_n(wait_n)
  );
endmodule

// File: rtl/wst_checker.sv
module wst_checker
  import wst_pkg::*;
#(
  parameter int NORM_WAITS  = 1,
  parameter int TURBO_WAITS = 2
) (
  input logic   clk,
  input logic   rst_n,
  input logic   mreq_n,
  input logic   iorq_n,
  input logic   m1_n,
  input logic   turbo_i,
  input logic   wait_n,
  input wmode_e mode
);
  logic [7:0] run_len;
  logic       turbo_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      turbo_lat <= 1'b0;
    end else begin
      run_len <= wait_n ? 8'd0 : run_len + 8'd1;
      if (wait_n) turbo_lat <= turbo_i;
    end
  end

  always @(posedge clk) if (!rst_n) AST_RESET_IDLE: assert (wait_n); // R1

  AST_ALL_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_ALL && !mreq_n && $past(mreq_n)) |=> !wait_n); // R2
  AST_FETCH_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_FETCH && !mreq_n && $past(mreq_n) && !m1_n) |=> !wait_n); // R3
  AST_FETCH_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_FETCH && m1_n && wait_n) |=> wait_n); // R4
  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_n) |-> (run_len == (turbo_lat ? 8'(TURBO_WAITS) : 8'(NORM_WAITS)))); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_OFF && wait_n) |=> wait_n); // R6
  AST_IO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n && wait_n) |=> wait_n); // R7
  AST_MODE_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(iorq_n)); // R8
endmodule

bind mem_wait_stretch wst_checker #(
  .NORM_WAITS(NORM_WAITS), .TURBO_WAITS(TURBO_WAITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
  .turbo_i(turbo_i), .wait_n(wait_n), .mode(cur_mode)
);

// File: tb/sim_mem_wait_stretch.sv
module sim_mem_wait_stretch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, wr_n = 1'b1, turbo = 1'b0;
  logic [7:0] addr = 8'h00, data = 8'h00;
  logic       wait_n;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;
  int         cur_pol = 2;   // 0 all, 1 fetch, 2 off

  always #5 clk = ~clk;

  mem_wait_stretch u0 (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
    .wr_n(wr_n), .addr_i(addr), .data_i(data), .turbo_i(turbo), .wait_n(wait_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wait_n=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 fetch, 1 read, 2 write
  task automatic mem_cycle(input int kind, input string req);
    int n;
    bit cov;
    cov = (cur_pol == 0) || (cur_pol == 1 && kind == 0);
    n = cov ? (turbo ? 2 : 1) : 0;
    @(negedge clk);
    mreq_n = 1'b0; m1_n = (kind != 0); wr_n = (kind != 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req, wait_n, (i < n) ? 1'b0 : 1'b1);
    end
    mreq_n = 1'b1; m1_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; iorq_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 io cycle", wait_n, 1'b1);
    end
    iorq_n = 1'b1; wr_n = 1'b1;
    if (a == 8'hBF) cur_pol = d[3] ? 2 : (d[2] ? 1 : 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", wait_n, 1'b1);
    rst_n = 1'b1;
    // R1: disabled after reset
    for (int k = 0; k < 3; k++) mem_cycle(k, "R1 default off");
    // R8/R2/R3/R4/R5/R6 sweep over every data byte and both turbo settings
    for (int d = 0; d < 256; d++) begin
      io_write(8'hBF, 8'(d));
      for (int t = 0; t < 2; t++) begin
        turbo = t[0];
        mem_cycle(0, "R8/R3/R5 fetch");
        mem_cycle(1, "R2/R4/R6 read");
        mem_cycle(2, "R2/R4/R6 write");
      end
    end
    // R4: prefixed instruction, two M1 fetches in a row
    io_write(8'hBF, 8'h04);
    turbo = 1'b0;
    mem_cycle(0, "R4 prefix fetch");
    mem_cycle(0, "R4 opcode fetch");
    turbo = 1'b1;
    mem_cycle(0, "R4 prefix fetch turbo");
    mem_cycle(0, "R4 opcode fetch turbo");
    // R7: writes to other ports do not change the policy
    io_write(8'hBE, 8'h00);
    io_write(8'h3F, 8'h00);
    turbo = 1'b0;
    mem_cycle(1, "R7 other port ignored");
    // R6: disable with 2'b11 field
    io_write(8'hBF, 8'hFC);
    mem_cycle(0, "R6 off fetch");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end
endmodule